// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Configuration

This block is a 32-pin general-purpose I/O port driven from a simple word-wide register bus. Software owns an output word, which can be written whole or altered bit by bit through set-only and clear-only aliases, and a direction word with the same three ways of writing. Each pin also has its own small configuration word. That word selects direction, whether the input buffer is connected, and the pull applied to an undriven pin. The direction bit is shared: the port-wide direction word and bit 0 of every pin's configuration word are the same storage, so a change through either path shows in both.

Every external pin arrives as an enable and a level, which together mean driven-0, driven-1 or undriven. The block presents an output level and an output enable per pin. An input word is refreshed every clock from the external drive, the selected pull, a loopback of the block's own output when the pin is an output, or is frozen while the input buffer is disconnected. When a pin set to output is also driven from outside, an error flag is raised.

Register word addresses: output 0, output-set 1, output-clear 2, input 3, direction 4, direction-set 5, direction-clear 6, and pin i's configuration at 32+i. Configuration fields: bit 0 direction (1 = output), bit 1 input disconnect (1 = disconnected), bits [3:2] pull (3 = pull-up, 1 = pull-down, 0 or 2 = none).

Top module: `gpio_port`

## Requirements
- R1: After reset, words 0 to 6 read 0, every configuration word reads 0x2, pin_out and pin_oe are 0 and short_err is 0.
- R2: A write to word 0 loads the output word, a write to word 1 sets the bits given, a write to word 2 clears them; words 1 and 2 read back the output word, and pin_out follows the output word from the clock edge of the write.
- R3: Writes to word 4 (load), 5 (set bits) and 6 (clear bits) change direction, and bit 0 of each affected pin's configuration word reads the new direction; writing a configuration word sets its pin's direction from bit 0; pin_oe follows the direction word; words 5 and 6 read back the direction word.
- R4: For a pin set as input with its buffer connected (configuration bits [1:0] = 0), the input bit takes the external level one clock after the pin is driven.
- R5: While configuration bit 1 is 1, the pin's input bit keeps its value whatever the external drive.
- R6: For a connected input pin that is undriven, pull code 3 makes the input bit 1 and pull code 1 makes it 0.
- R7: For a connected input pin that is undriven with no pull (code 0 or 2), the input bit keeps its last value.
- R8: For a pin set as output with its buffer connected (configuration bits [1:0] = 0b01), the input bit follows the block's own output level.
- R9: short_err is 1 in the clock after any pin has both direction = output and external drive enabled, and 0 in the clock after no pin has.
- R10: Writes to the input word (3) or to unmapped words leave output, direction and input unchanged, and unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_en | input | 32 | Per-pin external drive enable (0 = undriven) |
| ext_val | input | 32 | Per-pin external drive level |
| pin_out | output | 32 | Per-pin output level |
| pin_oe | output | 32 | Per-pin output enable (direction) |
| short_err | output | 1 | Output pin also driven externally |

## Verification
The assertions watch, on every cycle, that set and clear writes reach pin_out and pin_oe on the next edge, that writes to the input word leave outputs untouched, and that the short-circuit flag tracks the overlap of output enables with external drive. The mirroring of direction into the configuration words, the input resolution through pulls, hold, disconnect and loopback, and the read-back of the alias words depend on sequences of writes and pin stimulus, so only the bench's scenarios show them.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;

    // Port-wide register word indices (low half of the address space)
    typedef enum logic [2:0] {
        REG_OUT    = 3'd0,
        REG_OUTSET = 3'd1,
        REG_OUTCLR = 3'd2,
        REG_IN     = 3'd3,
        REG_DIR    = 3'd4,
        REG_DIRSET = 3'd5,
        REG_DIRCLR = 3'd6
    } port_reg_e;

    // Pull selection codes in configuration bits [3:2]
    localparam logic [1:0] PULL_DOWN = 2'b01;
    localparam logic [1:0] PULL_UP   = 2'b11;

    // Configuration field positions
    localparam int CFG_DIR_BIT  = 0;
    localparam int CFG_DISC_BIT = 1;
    localparam int CFG_PULL_LSB = 2;

endpackage

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    parameter int PIN_W  = 5,
    parameter int SEL_W  = 5,
    parameter int ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [NPINS-1:0]       out_q,
    output logic [NPINS-1:0]       dir_q,
    output logic [NPINS-1:0]       disc_q,
    output logic [NPINS-1:0][1:0]  pull_q
);

    logic             cfg_hit;
    logic [SEL_W-1:0] sel;
    logic [PIN_W-1:0] pin_idx;
    logic [NPINS-1:0] wmask;

    assign cfg_hit = addr[ADDR_W-1];
    assign sel     = addr[SEL_W-1:0];
    assign pin_idx = addr[PIN_W-1:0];
    assign wmask   = wdata[NPINS-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            disc_q <= '1;
            pull_q <= '0;
        end else if (wr_en) begin
            if (cfg_hit) begin
                dir_q[pin_idx]  <= wdata[CFG_DIR_BIT];
                disc_q[pin_idx] <= wdata[CFG_DISC_BIT];
                pull_q[pin_idx] <= wdata[CFG_PULL_LSB +: 2];
            end else begin
                case (sel)
                    SEL_W'(REG_OUT):    out_q <= wmask;
                    SEL_W'(REG_OUTSET): out_q <= out_q | wmask;
                    SEL_W'(REG_OUTCLR): out_q <= out_q & ~wmask;
                    SEL_W'(REG_DIR):    dir_q <= wmask;
                    SEL_W'(REG_DIRSET): dir_q <= dir_q | wmask;
                    SEL_W'(REG_DIRCLR): dir_q <= dir_q & ~wmask;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_in_resolve.sv
`timescale 1ns/1ps
module gpio_in_resolve
    import gpio_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPINS-1:0]      dir_q,
    input  logic [NPINS-1:0]      disc_q,
    input  logic [NPINS-1:0][1:0] pull_q,
    input  logic [NPINS-1:0]      out_q,
    input  logic [NPINS-1:0]      ext_en,
    input  logic [NPINS-1:0]      ext_val,
    output logic [NPINS-1:0]      in_q
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic bit_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (!disc_q[i]) begin
                if (dir_q[i])
                    bit_q <= out_q[i];
                else if (ext_en[i])
                    bit_q <= ext_val[i];
                else if (pull_q[i] == PULL_UP)
                    bit_q <= 1'b1;
                else if (pull_q[i] == PULL_DOWN)
                    bit_q <= 1'b0;
            end
        end

        assign in_q[i] = bit_q;
    end

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    localparam int PIN_W  = $clog2(NPINS),
    localparam int SEL_W  = (PIN_W > 3) ? PIN_W : 3,
    localparam int ADDR_W = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  ext_en,
    input  logic [NPINS-1:0]  ext_val,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              short_err
);

    logic [NPINS-1:0]      out_q;
    logic [NPINS-1:0]      dir_q;
    logic [NPINS-1:0]      disc_q;
    logic [NPINS-1:0][1:0] pull_q;
    logic [NPINS-1:0]      in_q;
    logic                  short_q;
    logic [SEL_W-1:0]      rsel;
    logic [PIN_W-1:0]      ridx;

    gpio_regs #(
        .NPINS(NPINS), .DATA_W(DATA_W), .PIN_W(PIN_W),
        .SEL_W(SEL_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .out_q(out_q), .dir_q(dir_q),
        .disc_q(disc_q), .pull_q(pull_q)
    );

    gpio_in_resolve #(.NPINS(NPINS)) u_in (
        .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .disc_q(disc_q),
        .pull_q(pull_q), .out_q(out_q), .ext_en(ext_en),
        .ext_val(ext_val), .in_q(in_q)
    );

    assign rsel = bus_addr[SEL_W-1:0];
    assign ridx = bus_addr[PIN_W-1:0];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[ADDR_W-1]) begin
            bus_rdata = DATA_W'({pull_q[ridx], disc_q[ridx], dir_q[ridx]});
        end else begin
            case (rsel)
                SEL_W'(REG_OUT),
                SEL_W'(REG_OUTSET),
                SEL_W'(REG_OUTCLR): bus_rdata = DATA_W'(out_q);
                SEL_W'(REG_IN):     bus_rdata = DATA_W'(in_q);
                SEL_W'(REG_DIR),
                SEL_W'(REG_DIRSET),
                SEL_W'(REG_DIRCLR): bus_rdata = DATA_W'(dir_q);
                default:            bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            short_q <= 1'b0;
        else
            short_q <= |(dir_q & ext_en);
    end

    assign pin_out   = out_q;
    assign pin_oe    = dir_q;
    assign short_err = short_q;

endmodule

module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NPINS-1:0]  ext_en,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              short_err
);

    // R2
    out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_OUTSET)) |=>
        ((pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R2
    out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_OUTCLR)) |=>
        ((pin_out & $past(bus_wdata[NPINS-1:0])) == '0));

    // R3
    dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_DIRSET)) |=>
        ((pin_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

    // R9
    short_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pin_oe & ext_en)) |=> short_err);

    // R9
    short_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pin_oe & ext_en)) |=> !short_err);

    // R10
    in_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_IN)) |=>
        ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_port gpio_port_chk #(
    .NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ext_en(ext_en), .pin_out(pin_out),
    .pin_oe(pin_oe), .short_err(short_err)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;

    localparam int NPINS  = 32;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int CFG0   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NPINS-1:0]  ext_en = '0;
    logic [NPINS-1:0]  ext_val = '0;
    logic [NPINS-1:0]  pin_out;
    logic [NPINS-1:0]  pin_oe;
    logic              short_err;

    int n_chk = 0;
    int n_fail = 0;
    logic mon_req = 1'b0;

    // scoreboard queues: selector, mask, expected, tag
    int          sel_q[$];
    logic [31:0] mask_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    gpio_port #(.NPINS(NPINS), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_en(ext_en),
        .ext_val(ext_val), .pin_out(pin_out), .pin_oe(pin_oe),
        .short_err(short_err)
    );

    // monitor: pops one expected item per requested sample
    always @(negedge clk) begin
        if (mon_req) begin
            int          s;
            logic [31:0] m, e, act;
            string       t;
            s = sel_q.pop_front();
            m = mask_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            case (s)
                0:       act = bus_rdata;
                1:       act = pin_out;
                2:       act = pin_oe;
                default: act = {31'b0, short_err};
            endcase
            n_chk++;
            if ((act & m) !== e) begin
                n_fail++;
                $display("FAIL %s actual=%h expected=%h", t, act & m, e);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // driver: push expected item and request one sample
    task automatic expect_v(input int s, input int a, input logic [31:0] m,
                            input logic [31:0] e, input string t);
        bus_addr = ADDR_W'(a);
        sel_q.push_back(s); mask_q.push_back(m);
        exp_q.push_back(e & m); tag_q.push_back(t);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string t);
        expect_v(0, a, 32'hFFFF_FFFF, e, t);
    endtask

    task automatic rd_in0(input logic e, input string t);
        expect_v(0, 3, 32'h1, {31'b0, e}, t);
    endtask

    initial begin
        #(5.0 * 50000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        for (int a = 0; a < 7; a++) rd(a, 32'h0, "R1 port word");
        rd(CFG0, 32'h2, "R1 cfg pin0");
        rd(CFG0 + 31, 32'h2, "R1 cfg pin31");
        expect_v(1, 0, 32'hFFFF_FFFF, 32'h0, "R1 pin_out");
        expect_v(2, 0, 32'hFFFF_FFFF, 32'h0, "R1 pin_oe");
        expect_v(3, 0, 32'h1, 32'h0, "R1 short_err");

        // R3 direction paths and mirroring
        wr(5, 32'h8000_0001);
        rd(4, 32'h8000_0001, "R3 dirset dir");
        rd(5, 32'h8000_0001, "R3 dirset readback");
        rd(CFG0, 32'h3, "R3 dirset cfg0");
        rd(CFG0 + 31, 32'h3, "R3 dirset cfg31");
        expect_v(2, 0, 32'hFFFF_FFFF, 32'h8000_0001, "R3 pin_oe");
        wr(6, 32'h8000_0001);
        rd(4, 32'h0, "R3 dirclr dir");
        rd(CFG0, 32'h2, "R3 dirclr cfg0");
        rd(CFG0 + 31, 32'h2, "R3 dirclr cfg31");
        wr(4, 32'h8000_0001);
        rd(4, 32'h8000_0001, "R3 dir load");
        expect_v(0, CFG0 + 31, 32'h1, 32'h1, "R3 dir load cfg31");
        wr(4, 32'h0);
        wr(CFG0 + 5, 32'h1);
        rd(4, 32'h20, "R3 cfg write to dir");
        rd(CFG0 + 5, 32'h1, "R3 cfg5 readback");
        wr(CFG0 + 5, 32'h2);
        rd(4, 32'h0, "R3 cfg5 back to input");

        // R4 / R7 connected input
        wr(CFG0, 32'h0);
        ext_en = 32'h1; ext_val = 32'h0; settle(2);
        rd_in0(1'b0, "R4 driven low");
        ext_val = 32'h1; settle(2);
        rd_in0(1'b1, "R4 driven high");
        ext_en = 32'h0; settle(2);
        rd_in0(1'b1, "R7 undriven holds 1");

        // R6 pull-up / pull-down
        ext_en = 32'h1; ext_val = 32'h0; settle(2);
        rd_in0(1'b0, "R4 driven low again");
        ext_en = 32'h0; settle(2);
        rd_in0(1'b0, "R7 undriven holds 0");
        wr(CFG0, 32'hC); settle(2);
        rd_in0(1'b1, "R6 pull-up");
        rd(CFG0, 32'hC, "R6 cfg pull-up readback");
        wr(CFG0, 32'h0);
        ext_en = 32'h1; ext_val = 32'h1; settle(2);
        rd_in0(1'b1, "R4 driven high again");
        ext_en = 32'h0;
        wr(CFG0, 32'h4); settle(2);
        rd_in0(1'b0, "R6 pull-down");

        // R5 disconnect freezes input
        wr(CFG0, 32'h0);
        ext_en = 32'h1; ext_val = 32'h1; settle(2);
        rd_in0(1'b1, "R5 before disconnect");
        wr(CFG0, 32'h2);
        ext_val = 32'h0; settle(2);
        rd_in0(1'b1, "R5 disconnected holds");
        ext_en = 32'h0;

        // R2 output word and aliases
        wr(CFG0, 32'h3);
        expect_v(2, 0, 32'h1, 32'h1, "R2 cfg0 output enable");
        wr(1, 32'h1);
        expect_v(1, 0, 32'hFFFF_FFFF, 32'h1, "R2 outset pin_out");
        rd(1, 32'h1, "R2 outset readback");
        rd(2, 32'h1, "R2 outclr readback");
        wr(2, 32'h1);
        expect_v(1, 0, 32'hFFFF_FFFF, 32'h0, "R2 outclr pin_out");
        wr(0, 32'hA5A5_0000);
        wr(1, 32'h1);
        rd(0, 32'hA5A5_0001, "R2 set keeps others");
        wr(2, 32'hA500_0000);
        expect_v(1, 0, 32'hFFFF_FFFF, 32'h00A5_0001, "R2 clr keeps others");
        wr(0, 32'h0);

        // R8 loopback
        wr(CFG0, 32'h1);
        wr(1, 32'h1); settle(2);
        rd_in0(1'b1, "R8 loopback high");
        wr(2, 32'h1); settle(2);
        rd_in0(1'b0, "R8 loopback low");

        // R9 short-circuit flag
        ext_en = 32'h1; ext_val = 32'h1; settle(2);
        expect_v(3, 0, 32'h1, 32'h1, "R9 short raised");
        ext_en = 32'h0; settle(2);
        expect_v(3, 0, 32'h1, 32'h0, "R9 short cleared");
        ext_en = 32'h8; settle(2);
        expect_v(3, 0, 32'h1, 32'h0, "R9 input pin driven no short");
        ext_en = 32'h0;

        // R10 inert writes
        wr(3, 32'hFFFF_FFFF); settle(2);
        rd(3, 32'h0, "R10 input write ignored");
        wr(7, 32'hFFFF_FFFF); settle(1);
        expect_v(1, 0, 32'hFFFF_FFFF, 32'h0, "R10 unmapped pin_out");
        expect_v(2, 0, 32'hFFFF_FFFF, 32'h1, "R10 unmapped pin_oe");
        rd(7, 32'h0, "R10 unmapped reads 0");

        settle(2);
        if (sel_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sel_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule